// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Sensing

A 32-pin general-purpose I/O port controlled through a simple register bus. The bus is word addressed and has separate read and write strobes. Software sets each pin's direction and output value, reads back the synchronised pad state, and chooses how each pin raises an interrupt: low level, high level, rising edge, falling edge, or both edges.

Pad inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier. Each pin has a sticky status bit that is set whether or not the pin is masked. Status bits are cleared by writing ones to the status register.

Masked status is OR-reduced onto two request lines:
- `irq_lo` serves pins 0 to 15.
- `irq_hi` serves pins 16 to 31.

Top module: `gpio_irq_port`

## Requirements
- R1: The register index `bus_addr` selects 0 = data, 1 = direction, 2 = pad state, 3 = sense config for pins 0..15, 4 = sense config for pins 16..31, 5 = mask, 6 = status, 7 = both-edge select. A read strobe loads `bus_rdata` at the next clock edge, and `bus_rdata` holds between reads. The direction, config, mask and both-edge registers, and the data register for output pins, read back the value last written.
- R2: `pad_oe` equals the direction register (1 = output). `pad_out` equals the data register.
- R3: Pads pass through two synchroniser flops. The pad state register returns the synchronised pads. Reading the data register returns the synchronised pad for input pins and the written value for output pins. A pad edge sets the status bit at the third clock edge after the pad changes.
- R4: Each pin's sense field is 2 bits wide: 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. Pin p < 16 uses bits [2p+1:2p] of config register 3. Pin p ≥ 16 uses bits [2(p-16)+1:2(p-16)] of config register 4.
- R5: When a pin's both-edge bit is 1, the pin flags on both rising and falling edges, and its sense field is ignored.
- R6: Writing to the status register clears each bit written as 1. Bits written as 0 are unchanged.
- R7: Status bits are set regardless of the mask. `irq_lo` is the OR of status AND mask over pins 0..15, and `irq_hi` is the same over pins 16..31.
- R8: A level-sensed status bit is set again on every cycle its level holds, so a clear does not remove it while the level remains.
- R9: Synchronous reset clears all registers, synchronisers and `bus_rdata`, making every pin a masked input.
- R10: Writes to the pad state register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_out | output | 32 | Output values to pads |
| pad_oe | output | 32 | Output enables to pads |
| irq_lo | output | 1 | Interrupt request for pins 0..15 |
| irq_hi | output | 1 | Interrupt request for pins 16..31 |

## Verification
Each result has a fixed latency from its stimulus:
- `bus_rdata` is due one edge after the read strobe.
- `pad_out`, `pad_oe` and the interrupt lines follow a write or mask change at the same edge that takes the write.
- A pad change reaches the pad state register after two edges and a status bit after three.

A cycle-level reference model in the bench advances on each rising edge with these latencies. It is compared with every output at each falling edge. Directed checks wait at least four cycles after a pad change before reading status, so that no result depends on the exact edge at which it is due.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int PINS   = 32;
    localparam int HALF   = PINS / 2;
    localparam int ADDR_W = 3;
    localparam int SNS_W  = 2;

    typedef enum logic [SNS_W-1:0] {
        SNS_LOW  = 2'd0,
        SNS_HIGH = 2'd1,
        SNS_RISE = 2'd2,
        SNS_FALL = 2'd3
    } sense_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_DATA   = 3'd0,
        RA_DIR    = 3'd1,
        RA_PAD    = 3'd2,
        RA_CFG_LO = 3'd3,
        RA_CFG_HI = 3'd4,
        RA_MASK   = 3'd5,
        RA_STAT   = 3'd6,
        RA_BOTH   = 3'd7
    } reg_addr_t;

    typedef struct packed {
        logic [PINS-1:0]       data;
        logic [PINS-1:0]       dir;
        logic [SNS_W*PINS-1:0] cfg;
        logic [PINS-1:0]       mask;
        logic [PINS-1:0]       both;
    } ctrl_t;

    function automatic logic sense_hit(sense_t s, logic both, logic cur, logic prev);
        if (both) return cur ^ prev;
        case (s)
            SNS_LOW:  return ~cur;
            SNS_HIGH: return cur;
            SNS_RISE: return cur & ~prev;
            default:  return ~cur & prev;
        endcase
    endfunction
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign cur  = sync_q;
    assign prev = prev_q;

    // R3
    sync_chain_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (prev == $past(cur)));
endmodule

// File: rtl/gpio_sense_detect.sv
module gpio_sense_detect
    import gpio_irq_pkg::*;
(
    input  logic [SNS_W*PINS-1:0] cfg,
    input  logic [PINS-1:0]       both,
    input  logic [PINS-1:0]       cur,
    input  logic [PINS-1:0]       prev,
    output logic [PINS-1:0]       hit
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        sense_t mode;
        assign mode   = sense_t'(cfg[SNS_W*p +: SNS_W]);
        assign hit[p] = sense_hit(mode, both[p], cur[p], prev[p]);
    end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] hit,
    input  logic [PINS-1:0] clr,
    input  logic [PINS-1:0] mask,
    output logic [PINS-1:0] status,
    output logic            irq_lo,
    output logic            irq_hi
);
    logic [PINS-1:0] stat_q;
    logic [PINS-1:0] live;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr) | hit;
    end

    assign status = stat_q;
    assign live   = stat_q & mask;
    assign irq_lo = |live[HALF-1:0];
    assign irq_hi = |live[PINS-1:HALF];

    // R6
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (hit == '0) |=> ((status & $past(clr)) == '0));
    // R8
    level_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((status & $past(hit)) == $past(hit)));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hit == '0 && clr == '0) |=> $stable(status));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);
    ctrl_t           ctrl_q;
    logic [PINS-1:0] cur, prev, hit, status, clr, rd_mux, rdata_q;
    reg_addr_t       ra;

    assign ra = reg_addr_t'(bus_addr);

    gpio_pad_sync #(.W(PINS)) u_sync (
        .clk(clk), .rst(rst), .pad(pad_in), .cur(cur), .prev(prev)
    );

    gpio_sense_detect u_detect (
        .cfg(ctrl_q.cfg), .both(ctrl_q.both), .cur(cur), .prev(prev), .hit(hit)
    );

    assign clr = (bus_wr && ra == RA_STAT) ? bus_wdata : '0;

    gpio_irq_status u_status (
        .clk(clk), .rst(rst), .hit(hit), .clr(clr), .mask(ctrl_q.mask),
        .status(status), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (bus_wr) begin
            case (ra)
                RA_DATA:   ctrl_q.data <= bus_wdata;
                RA_DIR:    ctrl_q.dir  <= bus_wdata;
                RA_CFG_LO: ctrl_q.cfg[PINS-1:0] <= bus_wdata;
                RA_CFG_HI: ctrl_q.cfg[2*PINS-1:PINS] <= bus_wdata;
                RA_MASK:   ctrl_q.mask <= bus_wdata;
                RA_BOTH:   ctrl_q.both <= bus_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (ra)
            RA_DATA:   rd_mux = (ctrl_q.data & ctrl_q.dir) | (cur & ~ctrl_q.dir);
            RA_DIR:    rd_mux = ctrl_q.dir;
            RA_PAD:    rd_mux = cur;
            RA_CFG_LO: rd_mux = ctrl_q.cfg[PINS-1:0];
            RA_CFG_HI: rd_mux = ctrl_q.cfg[2*PINS-1:PINS];
            RA_MASK:   rd_mux = ctrl_q.mask;
            RA_STAT:   rd_mux = status;
            default:   rd_mux = ctrl_q.both;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign pad_out   = ctrl_q.data;
    assign pad_oe    = ctrl_q.dir;

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_DIR) |=> (pad_oe == $past(bus_wdata)));
    // R1
    cfg_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_CFG_HI && !bus_rd) ##1 (bus_rd && bus_addr == RA_CFG_HI && !bus_wr)
        |=> (bus_rdata == $past(bus_wdata, 2)));
    // R1
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
    logic        irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_irq_port dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // behavioural reference model
    logic [31:0] m_data, m_dir, m_cfgl, m_cfgh, m_mask, m_stat, m_both;
    logic [31:0] m_s1, m_s2, m_prev, m_rdata;
    logic [31:0] t_ev, t_clr;
    int t_sns;
    bit t_hit;

    always @(posedge clk) begin
        if (rst) begin
            m_data <= 0; m_dir <= 0; m_cfgl <= 0; m_cfgh <= 0; m_mask <= 0;
            m_stat <= 0; m_both <= 0; m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_rdata <= 0;
        end else begin
            t_ev = 0;
            for (int p = 0; p < 32; p++) begin
                t_sns = (p < 16) ? int'((m_cfgl >> (2*p)) & 3) : int'((m_cfgh >> (2*(p-16))) & 3);
                if (m_both[p]) t_hit = m_s2[p] != m_prev[p];
                else if (t_sns == 0) t_hit = !m_s2[p];
                else if (t_sns == 1) t_hit = m_s2[p];
                else if (t_sns == 2) t_hit = m_s2[p] && !m_prev[p];
                else t_hit = !m_s2[p] && m_prev[p];
                t_ev[p] = t_hit;
            end
            t_clr = (bus_wr && bus_addr == 6) ? bus_wdata : 0;
            m_stat <= (m_stat & ~t_clr) | t_ev;
            if (bus_rd) begin
                case (bus_addr)
                    0: m_rdata <= (m_data & m_dir) | (m_s2 & ~m_dir);
                    1: m_rdata <= m_dir;
                    2: m_rdata <= m_s2;
                    3: m_rdata <= m_cfgl;
                    4: m_rdata <= m_cfgh;
                    5: m_rdata <= m_mask;
                    6: m_rdata <= m_stat;
                    default: m_rdata <= m_both;
                endcase
            end
            if (bus_wr) begin
                case (bus_addr)
                    0: m_data <= bus_wdata;
                    1: m_dir  <= bus_wdata;
                    3: m_cfgl <= bus_wdata;
                    4: m_cfgh <= bus_wdata;
                    5: m_mask <= bus_wdata;
                    7: m_both <= bus_wdata;
                    default: ;
                endcase
            end
            m_s1 <= pad_in; m_s2 <= m_s1; m_prev <= m_s2;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check("R2 pad_out", pad_out, m_data);
            check("R2 pad_oe", pad_oe, m_dir);
            check("R1 rdata", bus_rdata, m_rdata);
            check("R7 irq_lo", {31'b0, irq_lo}, {31'b0, |(m_stat[15:0] & m_mask[15:0])});
            check("R7 irq_hi", {31'b0, irq_hi}, {31'b0, |(m_stat[31:16] & m_mask[31:16])});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        @(negedge clk); d = bus_rdata; bus_rd = 0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] lfsr;
        waitc(3); rst = 0;
        // R9 reset state
        rd(5, v); check("R9 mask after reset", v, 0);
        rd(1, v); check("R9 dir after reset", v, 0);
        rd(7, v); check("R9 both-edge after reset", v, 0);
        // R2 outputs, R1 data readback
        wr(1, 32'h0000_00FF);
        wr(0, 32'hA5A5_A5A5);
        check("R2 pad_oe", pad_oe, 32'h0000_00FF);
        check("R2 pad_out", pad_out, 32'hA5A5_A5A5);
        pad_in = 32'h1234_5600;
        waitc(4);
        rd(0, v); check("R3 data mixes pad and latch", v, 32'h1234_56A5);
        rd(2, v); check("R3 pad state", v, 32'h1234_5600);
        // R10 pad state write ignored
        wr(2, 32'hFFFF_FFFF);
        rd(2, v); check("R10 pad state unchanged", v, 32'h1234_5600);
        wr(1, 0);
        // R4 / R6 rising edge on pin 0
        pad_in = 0;
        wr(3, 32'h0000_0002);
        wr(4, 32'hC000_0001);
        waitc(5);
        wr(6, 32'hFFFF_FFFF);
        rd(6, v); check("R6 rise bit cleared", v & 1, 0);
        pad_in[0] = 1; waitc(4);
        rd(6, v); check("R4 rising edge flagged", v & 1, 1);
        wr(6, 32'hFFFF_FFFE);
        rd(6, v); check("R6 zero write keeps bit", v & 1, 1);
        wr(6, 32'h0000_0001);
        rd(6, v); check("R6 one write clears bit", v & 1, 0);
        // R8 level high on pin 16
        pad_in[16] = 1; waitc(4);
        wr(6, 32'h0001_0000);
        rd(6, v); check("R8 level bit re-set", (v >> 16) & 1, 1);
        // R7 masking
        check("R7 masked irq_hi low", {31'b0, irq_hi}, 0);
        wr(5, 32'h0001_0000);
        check("R7 unmasked irq_hi high", {31'b0, irq_hi}, 1);
        check("R7 irq_lo stays low", {31'b0, irq_lo}, 0);
        wr(5, 0);
        // R5 both edges on pin 1 overriding low-level field
        wr(7, 32'h0000_0002);
        wr(6, 32'h0000_0002);
        waitc(3);
        rd(6, v); check("R5 sense field ignored", (v >> 1) & 1, 0);
        pad_in[1] = 1; waitc(4);
        rd(6, v); check("R5 rise flagged", (v >> 1) & 1, 1);
        wr(6, 32'h0000_0002);
        pad_in[1] = 0; waitc(4);
        rd(6, v); check("R5 fall flagged", (v >> 1) & 1, 1);
        // R4 falling edge on pin 31 via upper config
        pad_in[31] = 1; waitc(4);
        wr(6, 32'h8000_0000);
        rd(6, v); check("R4 no fall yet", v >> 31, 0);
        pad_in[31] = 0; waitc(4);
        rd(6, v); check("R4 fall flagged pin 31", v >> 31, 1);
        // R3 latency: status set on third edge after pad change
        wr(6, 32'h0000_0001);
        pad_in[0] = 0; waitc(2);
        pad_in[0] = 1; waitc(2);
        check("R3 not yet flagged", m_stat & 1, 0);
        // mixed traffic compared by the model every cycle
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            pad_in = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            case (i % 6)
                0: wr(3, lfsr);
                1: wr(5, ~lfsr);
                2: wr(7, lfsr & 32'h0F0F_0F0F);
                3: wr(6, lfsr);
                4: wr(1, lfsr & 32'h00FF_00FF);
                default: wr(4, ~lfsr);
            endcase
            rd(3'(i % 8), v);
            wr(0, lfsr);
        end
        waitc(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule